// File: doc/BRIEF.md
# Up-Counting Cycle Interrupt Timer

This block is an interrupt source that sits on the cartridge side of an 8-bit CPU bus. Software builds a 16-bit start value with four short writes, each carrying one nibble. A control write then arms the timer. While armed, the timer counts CPU cycles upward. When it reaches the top of its range it restarts from the start value and raises an interrupt request. That request stays high until software acknowledges it.

The block decodes only the upper four address bits of each write, so every register shows up across a whole 4 KiB window. Two separate write windows act as acknowledges. One of them, the control window, can also stop or restart the count. The other clears the request and does nothing else. A per-cycle enable input qualifies each counting step, so the host can freeze time without disarming the timer.

Top module: `irq_cycle_timer`

## Requirements
- R1: Reset leaves the timer disarmed, the count and the start value at zero, and `irq` low. Arming right after reset with no start-value writes makes the first interrupt come 65535 counted cycles after the arming write.
- R2: A write whose `addr_hi` is 0x8, 0x9, 0xA or 0xB stores `wdata[3:0]` into start-value bits [3:0], [7:4], [11:8] or [15:12] in that order. `wdata[7:4]` is ignored.
- R3: A write with `addr_hi` 0xC arms the timer when `wdata[3:0]` is nonzero and disarms it when `wdata[3:0]` is zero. A nonzero value also copies the start value into the count, and no counting step happens in that cycle.
- R4: Every write with `addr_hi` 0xC drops a pending `irq` in the following cycle.
- R5: A write with `addr_hi` 0xD drops a pending `irq`. It leaves the count, the arming and the start value unchanged, and a count in progress keeps its timing.
- R6: While the timer is armed, each rising edge with `cyc_en` high advances the count by one. Edges with `cyc_en` low leave the count as it is.
- R7: On an armed, enabled edge where the count is 0xFFFE or 0xFFFF, the count is replaced by the start value and `irq` goes high after that edge. A start value L therefore gives a period of max(1, 0xFFFF - L) counted edges.
- R8: While the timer is disarmed, no new interrupt is raised, whatever `cyc_en` does.
- R9: `irq` stays high until an acknowledge write (0xC or 0xD). When a 0xD write and a terminal step fall on the same edge, `irq` stays high.
- R10: Start-value writes made during a count do not change that count. The new value takes effect at the next reload.
- R11: Writes with `addr_hi` in 0x0 to 0x7, 0xE or 0xF change no state. The period in progress and the start value are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| addr_hi | input | 4 | Address bits 15..12 of the write |
| wdata | input | 8 | Write data |
| cyc_en | input | 1 | Count-enable qualifier for this cycle |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest case to reach is the collision of a terminal step with a plain acknowledge on the same edge. It needs the count to be one step from the top at the exact cycle of the 0xD write. The bench sets this up with a start value of 0xFFFE, which gives a period of one edge. It holds `cyc_en` low after the first interrupt so the count parks at 0xFFFE, then issues the acknowledge with `cyc_en` high. The effect of a mid-count start-value write is only visible through timing, so the bench measures two successive periods and checks that only the second one reflects the new value.

// File: rtl/irq_tmr_pkg.sv
package irq_tmr_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_LOAD = 2'd1,
      OP_CTRL = 2'd2,
      OP_ACK  = 2'd3
   } op_e;
endpackage

// File: rtl/irq_tmr_decode.sv
module irq_tmr_decode
   import irq_tmr_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int NFIELD    = 4,
   parameter int LOAD_BASE = 8,
   parameter int CTRL_CODE = 12,
   parameter int ACK_CODE  = 13
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr_hi,
   output op_e               op,
   output logic [NFIELD-1:0] field_sel
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_CODE);
   localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_CODE);

   // one strobe per start-value nibble
   for (genvar i = 0; i < NFIELD; i++) begin : g_field
      localparam logic [ADDR_W-1:0] CODE = ADDR_W'(LOAD_BASE + i);
      assign field_sel[i] = wr_en && (addr_hi == CODE);
   end

   always_comb begin
      op = OP_NONE;
      if (wr_en) begin
         if (|field_sel)             op = OP_LOAD;
         else if (addr_hi == CTRL_A) op = OP_CTRL;
         else if (addr_hi == ACK_A)  op = OP_ACK;
      end
   end
endmodule

// File: rtl/irq_tmr_reload.sv
module irq_tmr_reload #(
   parameter int CNT_W  = 16,
   parameter int NIB_W  = 4,
   parameter int NFIELD = CNT_W / NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NFIELD-1:0] field_sel,
   input  logic [NIB_W-1:0]  nib_in,
   output logic [CNT_W-1:0]  reload
);
   for (genvar i = 0; i < NFIELD; i++) begin : g_nib
      logic [NIB_W-1:0] nib_q;
      always_ff @(posedge clk) begin
         if (!rst_n)            nib_q <= '0;
         else if (field_sel[i]) nib_q <= nib_in;
      end
      assign reload[i*NIB_W +: NIB_W] = nib_q;
   end
endmodule

// File: rtl/irq_tmr_counter.sv
module irq_tmr_counter
   import irq_tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  op_e              op,
   input  logic             ctrl_arm,
   input  logic             cyc_en,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             armed,
   output logic             term
);
   // a step from here lands on (or past) all ones
   localparam logic [CNT_W-1:0] NEAR_TOP = {{(CNT_W-1){1'b1}}, 1'b0};

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             step;

   assign step = armed_q && cyc_en && (op != OP_CTRL);
   assign term = step && (cnt_q >= NEAR_TOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (op == OP_CTRL) begin
         armed_q <= ctrl_arm;
         if (ctrl_arm) cnt_q <= reload;
      end else if (term) begin
         cnt_q <= reload;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt   = cnt_q;
   assign armed = armed_q;
endmodule

// File: rtl/irq_tmr_flag.sv
module irq_tmr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq
);
   logic irq_q;
   // a new event outranks an acknowledge in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)   irq_q <= 1'b0;
      else if (set) irq_q <= 1'b1;
      else if (clr) irq_q <= 1'b0;
   end
   assign irq = irq_q;
endmodule

// File: rtl/irq_cycle_timer.sv
module irq_cycle_timer
   import irq_tmr_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int NIB_W     = 4,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int LOAD_BASE = 8,
   parameter int CTRL_CODE = 12,
   parameter int ACK_CODE  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cyc_en,
   output logic              irq
);
   localparam int NFIELD = CNT_W / NIB_W;

   if (CNT_W % NIB_W != 0) begin : g_bad_split
      $error("CNT_W must be a whole number of nibbles");
   end
   if (NIB_W > DATA_W) begin : g_bad_nib
      $error("NIB_W exceeds data width");
   end
   if (LOAD_BASE + NFIELD > CTRL_CODE || CTRL_CODE == ACK_CODE) begin : g_bad_map
      $error("write codes overlap");
   end
   if (ACK_CODE >= (1 << ADDR_W) || CTRL_CODE >= (1 << ADDR_W)) begin : g_bad_code
      $error("write code outside address field");
   end

   op_e              op;
   logic [NFIELD-1:0] field_sel;
   logic [CNT_W-1:0]  reload_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              armed_q;
   logic              term_evt;
   logic              ctrl_arm;
   logic              ack_any;

   assign ctrl_arm = |wdata[NIB_W-1:0];
   assign ack_any  = (op == OP_CTRL) || (op == OP_ACK);

   if (DATA_W > NIB_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:NIB_W];
   end

   irq_tmr_decode #(
      .ADDR_W(ADDR_W), .NFIELD(NFIELD), .LOAD_BASE(LOAD_BASE),
      .CTRL_CODE(CTRL_CODE), .ACK_CODE(ACK_CODE)
   ) u_dec (
      .wr_en(wr_en), .addr_hi(addr_hi), .op(op), .field_sel(field_sel)
   );

   irq_tmr_reload #(.CNT_W(CNT_W), .NIB_W(NIB_W), .NFIELD(NFIELD)) u_rld (
      .clk(clk), .rst_n(rst_n), .field_sel(field_sel),
      .nib_in(wdata[NIB_W-1:0]), .reload(reload_q)
   );

   irq_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .op(op), .ctrl_arm(ctrl_arm),
      .cyc_en(cyc_en), .reload(reload_q), .cnt(cnt_q),
      .armed(armed_q), .term(term_evt)
   );

   irq_tmr_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(term_evt), .clr(ack_any), .irq(irq)
   );
endmodule

// File: rtl/irq_cycle_timer_chk.sv
module irq_cycle_timer_chk #(
   parameter int CNT_W     = 16,
   parameter int NIB_W     = 4,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int CTRL_CODE = 12,
   parameter int ACK_CODE  = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr_hi,
   input logic [DATA_W-1:0] wdata,
   input logic              cyc_en,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt,
   input logic              armed,
   input logic              term,
   input logic [CNT_W-1:0]  reload
);
   localparam logic [ADDR_W-1:0] C_A = ADDR_W'(CTRL_CODE);
   localparam logic [ADDR_W-1:0] D_A = ADDR_W'(ACK_CODE);
   localparam logic [CNT_W-1:0]  ONE = 1;

   logic ctrl_w, ack_w, arm_v;
   assign ctrl_w = wr_en && (addr_hi == C_A);
   assign ack_w  = wr_en && (addr_hi == D_A);
   assign arm_v  = |wdata[NIB_W-1:0];

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq && !armed && cnt == '0));
   assert_arm_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_w && arm_v |=> (armed && cnt == $past(reload)));
   assert_disarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_w && !arm_v |=> !armed);
   assert_ctrl_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_w |=> !irq);
   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_w && !term |=> !irq);
   assert_ack_keeps_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_w |=> armed == $past(armed));
   assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && cyc_en && !ctrl_w && !term |=> cnt == $past(cnt) + ONE);
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_en && !ctrl_w |=> $stable(cnt));
   assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      term |=> (irq && cnt == $past(reload)));
   assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !term);
   assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq && !term |=> !irq);
   assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !ctrl_w && !ack_w |=> irq);
endmodule

bind irq_cycle_timer irq_cycle_timer_chk #(
   .CNT_W(CNT_W), .NIB_W(NIB_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .CTRL_CODE(CTRL_CODE), .ACK_CODE(ACK_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_hi(addr_hi),
   .wdata(wdata), .cyc_en(cyc_en), .irq(irq), .cnt(cnt_q),
   .armed(armed_q), .term(term_evt), .reload(reload_q)
);

// File: tb/tb_irq_cycle_timer.sv
`timescale 1ns/1ps
module tb_irq_cycle_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] addr_hi = 4'h0;
   logic [7:0] wdata = 8'h00;
   logic       cyc_en = 1'b0;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   irq_cycle_timer dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_hi(addr_hi),
      .wdata(wdata), .cyc_en(cyc_en), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one cycle of inputs; returns at the following falling edge
   task automatic step(input bit we, input logic [3:0] a, input logic [7:0] d, input bit ce);
      wr_en = we; addr_hi = a; wdata = d; cyc_en = ce;
      @(negedge clk);
      wr_en = 1'b0; cyc_en = 1'b0;
   endtask

   task automatic load_start(input logic [15:0] v, input bit ce);
      step(1'b1, 4'h8, {4'hA, v[3:0]}, ce);
      step(1'b1, 4'h9, {4'h5, v[7:4]}, ce);
      step(1'b1, 4'hA, {4'hC, v[11:8]}, ce);
      step(1'b1, 4'hB, {4'h3, v[15:12]}, ce);
   endtask

   task automatic arm(input logic [15:0] v);
      load_start(v, 1'b0);
      step(1'b1, 4'hC, 8'h93, 1'b0);
   endtask

   function automatic int period(input int v);
      return (v >= 16'hFFFE) ? 1 : 16'hFFFF - v;
   endfunction

   // counts enabled edges until irq is seen; -1 if never
   task automatic measure(input int limit, input bit gated, output int n);
      n = 0;
      for (int i = 1; i <= limit; i++) begin
         bit ce;
         ce = gated ? (i % 3 != 0) : 1'b1;
         step(1'b0, 4'h0, 8'h00, ce);
         if (ce) n++;
         if (irq) return;
      end
      n = -1;
   endtask

   task automatic run(input int k, input bit ce);
      for (int i = 0; i < k; i++) step(1'b0, 4'h0, 8'h00, ce);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #800000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(irq == 1'b0, "R1 irq after reset", irq, 0);
      run(60, 1'b1);
      check(irq == 1'b0, "R8 disarmed after reset", irq, 0);

      // R1: start value zero after reset -> full-length period
      step(1'b1, 4'hC, 8'h01, 1'b0);
      measure(70000, 1'b0, n);
      check(n == 65535, "R1 period from reset start value", n, 65535);

      // R2 / R7: sweep each nibble field
      for (int v = 0; v < 16; v++) begin
         int l;
         l = 16'hFFF0 | v;
         arm(16'(l)); measure(300, 1'b0, n);
         check(n == period(l), "R2 field0 period", n, period(l));
      end
      for (int v = 0; v < 16; v++) begin
         int l;
         l = 16'hFF0F | (v << 4);
         arm(16'(l)); measure(800, 1'b1, n);
         check(n == period(l), "R6 R2 field1 gated period", n, period(l));
      end
      for (int v = 0; v < 16; v++) begin
         int l;
         l = 16'hF0FF | (v << 8);
         arm(16'(l)); measure(5000, 1'b0, n);
         check(n == period(l), "R2 field2 period", n, period(l));
      end
      for (int v = 14; v < 16; v++) begin
         int l;
         l = 16'h0FFF | (v << 12);
         arm(16'(l)); measure(5000, 1'b0, n);
         check(n == period(l), "R2 field3 period", n, period(l));
      end

      // R7 second period after reload, R5 acknowledge counted as a normal cycle
      arm(16'hFF00); measure(400, 1'b0, n);
      check(n == 255, "R7 first period", n, 255);
      step(1'b1, 4'hD, 8'hFF, 1'b1);
      check(irq == 1'b0, "R5 ack clears irq", irq, 0);
      measure(400, 1'b0, n);
      check(n == 254, "R7 reload period after ack", n, 254);

      // R5: ack mid-count keeps timing
      arm(16'hFF00); run(100, 1'b1);
      step(1'b1, 4'hD, 8'h00, 1'b1);
      measure(400, 1'b0, n);
      check(n == 154, "R5 ack mid-count timing", n, 154);

      // R10: start-value change during a count
      arm(16'hFF00); run(100, 1'b1);
      load_start(16'hFFF0, 1'b1);
      measure(400, 1'b0, n);
      check(n == 151, "R10 running count unaffected", n, 151);
      step(1'b1, 4'hD, 8'h00, 1'b0);
      measure(400, 1'b0, n);
      check(n == 15, "R10 new value at next reload", n, 15);

      // R9: hold and collision with ack
      arm(16'hFFFE); step(1'b0, 4'h0, 8'h00, 1'b1);
      check(irq == 1'b1, "R7 one-edge period", irq, 1);
      run(20, 1'b0);
      check(irq == 1'b1, "R9 irq held", irq, 1);
      step(1'b1, 4'hD, 8'h00, 1'b1);
      check(irq == 1'b1, "R9 terminal beats ack", irq, 1);
      step(1'b1, 4'hD, 8'h00, 1'b0);
      check(irq == 1'b0, "R5 plain ack", irq, 0);

      // R4 / R8: control write with zero clears and disarms
      arm(16'hFFFE); step(1'b0, 4'h0, 8'h00, 1'b1);
      step(1'b1, 4'hC, 8'h00, 1'b1);
      check(irq == 1'b0, "R4 control write clears irq", irq, 0);
      run(300, 1'b1);
      check(irq == 1'b0, "R8 no irq while disarmed", irq, 0);

      // R3: upper data nibble does not arm
      arm(16'hFF00); run(50, 1'b1);
      step(1'b1, 4'hC, 8'hF0, 1'b1);
      run(400, 1'b1);
      check(irq == 1'b0, "R3 low-nibble-zero disarms", irq, 0);

      // R3: re-arm restarts count
      arm(16'hFF00); run(200, 1'b1);
      step(1'b1, 4'hC, 8'h08, 1'b1);
      measure(400, 1'b0, n);
      check(n == 255, "R3 re-arm reloads count", n, 255);

      // R11: writes to unused windows
      step(1'b1, 4'hD, 8'h00, 1'b0);
      arm(16'hFF80);
      for (int c = 0; c < 16; c++) begin
         if (c < 8 || c > 13) step(1'b1, 4'(c), 8'hFF, 1'b1);
      end
      measure(400, 1'b0, n);
      check(n == 117, "R11 unused writes keep timing", n, 117);
      step(1'b1, 4'hD, 8'h00, 1'b0);
      measure(400, 1'b0, n);
      check(n == 127, "R11 unused writes keep start value", n, 127);

      summary();
      $finish;
   end
endmodule